// File: doc/BRIEF.md
# ADC Overrange Detector

This block raises an overload flag for a sigma-delta converter datapath. It watches two input streams. The first is the signed output of the first decimation stage. The block compares that value, before any gain or offset correction, against a programmable 16-bit threshold, so the flag comes with little delay. The second stream is a per-sample flag from the modulator that says the input has gone beyond full reference. When that flag stays high for a run of consecutive modulator samples, it trips a fast path.

The threshold sits behind a simple address/data/write-enable register port and can be read back. The flag appears on its own output pin and as one bit of a read-only status word. A parameter selects one of two behaviours for the flag. In level mode it follows the live detection. In sticky mode it holds until software clears it.

Top module: `adc_ovr_detect`

## Requirements
- R1: After reset, the threshold register holds 0xCCCC, reads back at address 0x5, and `ovr_o` is 0.
- R2: A write with `reg_we_i`=1 at address 0x5 loads `reg_wdata_i` into the threshold. A write to any other address, or with `reg_we_i`=0, leaves the threshold unchanged.
- R3: On a decimator sample (`dec_valid_i`=1), the block sets the threshold hit when 2×|sample|, taken as an unsigned 16-bit value, is strictly greater than the threshold. In level mode `ovr_o` shows this hit after the next rising clock edge. A value equal to the threshold does not set the hit.
- R4: The magnitude is the absolute value of the twos-complement sample. The value -32768 saturates to 32767, so its scaled magnitude is 65534.
- R5: The block counts modulator samples (`mod_valid_i`=1) that have `mod_over_i`=1. When the count of consecutive such samples goes past 4, the fast path is active and `ovr_o` is 1 after the edge of the 5th sample. Four consecutive samples do not set it.
- R6: A modulator sample with `mod_over_i`=0 resets the consecutive count to zero and ends the fast path.
- R7: In level mode, `ovr_o` returns to 0 after a decimator sample within the threshold, provided the fast path is not active.
- R8: A read at address 0x2 returns the status word, with the overrange flag in bit 8 and every other bit 0. A read at any address other than 0x2 or 0x5 returns 0.
- R9: In sticky mode (STICKY=1), `ovr_o` is set one cycle after a detection and stays set until a write to address 0x2. A pending detection takes priority over the clear.
- R10: While `dec_valid_i`=0, `dec_data_i` has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | First decimation stage sample strobe |
| dec_data_i | input | 16 | Signed decimator output |
| mod_valid_i | input | 1 | Modulator-rate sample strobe |
| mod_over_i | input | 1 | Modulator sample exceeds full reference |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from address) |
| ovr_o | output | 1 | Overrange flag |

## Verification
The threshold path is driven with positive and negative samples placed exactly at the default threshold and one code above it. This separates a strict compare from a non-strict one and shows that the sign is removed. The value -32768 is tried against thresholds of 0xFFFD and 0xFFFE, which separates a saturated magnitude from a wrapped or widened one. The fast path is given runs of four and five over-scale samples, and also broken runs, to fix both the trip count and the reset of the count. A second instance in sticky mode checks hold and clear against the level instance under the same stimulus.

// File: rtl/adc_ovr_pkg.sv
package adc_ovr_pkg;
  localparam int unsigned ADDR_STAT = 2;
  localparam int unsigned ADDR_THR  = 5;
  localparam int unsigned STAT_OVR_BIT = 8;
endpackage

// File: rtl/ovr_thr_reg.sv
module ovr_thr_reg #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4,
  parameter logic [DW-1:0] RST_VAL = 16'hCCCC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] thr_o
);
  import adc_ovr_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_o <= RST_VAL;
    else if (we_i && addr_i == AW'(ADDR_THR)) thr_o <= wdata_i;
  end
endmodule

// File: rtl/ovr_mag_cmp.sv
module ovr_mag_cmp #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] thr_i,
  output logic          hit_o
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] mag;
  logic [DW-1:0] mag_x2;

  always_comb begin
    if (data_i == MOST_NEG)  mag = MOST_POS;
    else if (data_i[DW-1])   mag = (~data_i) + 1'b1;
    else                     mag = data_i;
  end

  // magnitude is a fraction of full scale; threshold spans the full unsigned range
  assign mag_x2 = {mag[DW-2:0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hit_o <= 1'b0;
    else if (valid_i) hit_o <= (mag_x2 > thr_i);
  end
endmodule

// File: rtl/ovr_run_det.sv
module ovr_run_det #(
  parameter int unsigned RUN_LIMIT = 4,
  localparam int unsigned CW = $clog2(RUN_LIMIT + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          over_i,
  output logic [CW-1:0] run_o,
  output logic          fast_o
);
  localparam logic [CW-1:0] SAT = CW'(RUN_LIMIT + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (valid_i) begin
      if (!over_i)          run_q <= '0;
      else if (run_q != SAT) run_q <= run_q + 1'b1;
    end
  end

  assign run_o  = run_q;
  assign fast_o = (run_q > CW'(RUN_LIMIT));
endmodule

// File: rtl/adc_ovr_detect.sv
module adc_ovr_detect #(
  parameter int unsigned   DW        = 16,
  parameter int unsigned   AW        = 4,
  parameter int unsigned   RUN_LIMIT = 4,
  parameter bit            STICKY    = 1'b0,
  parameter logic [15:0]   THR_RST   = 16'hCCCC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_valid_i,
  input  logic [DW-1:0] dec_data_i,
  input  logic          mod_valid_i,
  input  logic          mod_over_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          ovr_o
);
  import adc_ovr_pkg::*;
  localparam int unsigned CW = $clog2(RUN_LIMIT + 2);

  logic [DW-1:0] thr;
  logic          thr_hit;
  logic          fast_hit;
  logic [CW-1:0] run_cnt;
  logic          det;

  ovr_thr_reg #(.DW(DW), .AW(AW), .RST_VAL(DW'(THR_RST))) u_thr (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .thr_o(thr)
  );

  ovr_mag_cmp #(.DW(DW)) u_cmp (
    .clk_i, .rst_ni,
    .valid_i(dec_valid_i), .data_i(dec_data_i), .thr_i(thr),
    .hit_o(thr_hit)
  );

  ovr_run_det #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk_i, .rst_ni,
    .valid_i(mod_valid_i), .over_i(mod_over_i),
    .run_o(run_cnt), .fast_o(fast_hit)
  );

  assign det = thr_hit | fast_hit;

  generate
    if (STICKY) begin : g_sticky
      logic ovr_q;
      logic clr;
      assign clr = reg_we_i && reg_addr_i == AW'(ADDR_STAT);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ovr_q <= 1'b0;
        else         ovr_q <= (ovr_q & ~clr) | det;
      end
      assign ovr_o = ovr_q;
    end else begin : g_level
      assign ovr_o = det;
    end
  endgenerate

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(ADDR_THR))       reg_rdata_o = thr;
    else if (reg_addr_i == AW'(ADDR_STAT)) reg_rdata_o[STAT_OVR_BIT] = ovr_o;
  end
endmodule

// File: rtl/adc_ovr_checker.sv
module adc_ovr_checker #(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 4,
  parameter int unsigned RUN_LIMIT = 4,
  parameter bit          STICKY    = 1'b0,
  localparam int unsigned CW = $clog2(RUN_LIMIT + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dec_valid_i,
  input logic          mod_valid_i,
  input logic          mod_over_i,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          ovr_o,
  input logic [DW-1:0] thr,
  input logic          thr_hit,
  input logic          fast_hit,
  input logic [CW-1:0] run_cnt
);
  import adc_ovr_pkg::*;

  p_thr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == AW'(ADDR_THR)) |=> $stable(thr));

  p_dec_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> $stable(thr_hit));

  p_fast_trip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_valid_i && mod_over_i && run_cnt == CW'(RUN_LIMIT)) |=> fast_hit);

  p_run_reset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_valid_i && !mod_over_i) |=> (run_cnt == '0));

  p_run_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= CW'(RUN_LIMIT + 1));

  p_level_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !STICKY |-> (ovr_o == (thr_hit | fast_hit)));

  p_sticky_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STICKY && ovr_o && !(reg_we_i && reg_addr_i == AW'(ADDR_STAT))) |=> ovr_o);

  p_status_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AW'(ADDR_STAT)) |-> (reg_rdata_o[STAT_OVR_BIT] == ovr_o));
endmodule

bind adc_ovr_detect adc_ovr_checker #(
  .DW(DW), .AW(AW), .RUN_LIMIT(RUN_LIMIT), .STICKY(STICKY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .dec_valid_i(dec_valid_i), .mod_valid_i(mod_valid_i), .mod_over_i(mod_over_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .ovr_o(ovr_o), .thr(thr), .thr_hit(thr_hit), .fast_hit(fast_hit),
  .run_cnt(run_cnt)
);

// File: tb/tb_adc_ovr_detect.sv
module tb_adc_ovr_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [15:0] dec_data = '0;
  logic        mod_valid = 1'b0;
  logic        mod_over = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata_s;
  logic        ovr, ovr_s;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  adc_ovr_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid), .dec_data_i(dec_data),
    .mod_valid_i(mod_valid), .mod_over_i(mod_over), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ovr_o(ovr)
  );

  adc_ovr_detect #(.STICKY(1'b1)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid), .dec_data_i(dec_data),
    .mod_valid_i(mod_valid), .mod_over_i(mod_over), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_s), .ovr_o(ovr_s)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; results read on the next falling edge
  task automatic dec_sample(input logic [15:0] d);
    dec_valid = 1'b1; dec_data = d;
    @(negedge clk);
    dec_valid = 1'b0; dec_data = '0;
  endtask

  task automatic mod_sample(input logic o);
    mod_valid = 1'b1; mod_over = o;
    @(negedge clk);
    mod_valid = 1'b0; mod_over = 1'b0;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d, input logic en);
    addr = a; wdata = d; we = en;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = '0;
  endtask

  task automatic t_reset;
    logic [15:0] r;
    reg_read(4'h5, r); chk("R1 thr reset", r, 16'hCCCC);
    chk("R1 ovr reset", {15'b0, ovr}, 16'h0);
    reg_read(4'h2, r); chk("R8 status reset", r, 16'h0);
    reg_read(4'h7, r); chk("R8 unmapped read", r, 16'h0);
  endtask

  task automatic t_threshold;
    logic [15:0] r;
    dec_sample(16'd26214);  chk("R3 equal no trip", {15'b0, ovr}, 16'h0);
    dec_sample(16'd26215);  chk("R3 above trips", {15'b0, ovr}, 16'h1);
    reg_read(4'h2, r);      chk("R8 status bit8", r, 16'h0100);
    dec_sample(16'd100);    chk("R7 clears in range", {15'b0, ovr}, 16'h0);
    dec_sample(-16'sd26215); chk("R4 negative trips", {15'b0, ovr}, 16'h1);
    dec_sample(-16'sd26214); chk("R4 negative equal clears", {15'b0, ovr}, 16'h0);
  endtask

  task automatic t_ignore;
    dec_data = 16'h7FFF;
    @(negedge clk); @(negedge clk);
    chk("R10 no strobe ignored", {15'b0, ovr}, 16'h0);
    dec_data = '0;
  endtask

  task automatic t_regs;
    logic [15:0] r;
    reg_write(4'h4, 16'h1234, 1'b1);
    reg_read(4'h5, r); chk("R2 other addr", r, 16'hCCCC);
    reg_write(4'h5, 16'h1234, 1'b0);
    reg_read(4'h5, r); chk("R2 no enable", r, 16'hCCCC);
    reg_write(4'h5, 16'hFFFD, 1'b1);
    reg_read(4'h5, r); chk("R2 write", r, 16'hFFFD);
  endtask

  task automatic t_saturate;
    dec_sample(16'h8000); chk("R4 -32768 vs FFFD", {15'b0, ovr}, 16'h1);
    reg_write(4'h5, 16'hFFFE, 1'b1);
    dec_sample(16'h8000); chk("R4 -32768 vs FFFE", {15'b0, ovr}, 16'h0);
    reg_write(4'h5, 16'hCCCC, 1'b1);
  endtask

  task automatic t_fast;
    for (int i = 0; i < 4; i++) mod_sample(1'b1);
    chk("R5 four no trip", {15'b0, ovr}, 16'h0);
    mod_sample(1'b1);
    chk("R5 fifth trips", {15'b0, ovr}, 16'h1);
    dec_sample(16'd0);
    chk("R7 fast holds flag", {15'b0, ovr}, 16'h1);
    mod_sample(1'b0);
    chk("R6 under clears", {15'b0, ovr}, 16'h0);
    for (int i = 0; i < 3; i++) mod_sample(1'b1);
    mod_sample(1'b0);
    for (int i = 0; i < 3; i++) mod_sample(1'b1);
    chk("R6 broken run", {15'b0, ovr}, 16'h0);
    mod_sample(1'b0);
  endtask

  task automatic t_sticky;
    dec_sample(16'h7000);
    @(negedge clk);
    chk("R9 sticky set", {15'b0, ovr_s}, 16'h1);
    dec_sample(16'd5);
    @(negedge clk);
    chk("R9 level cleared", {15'b0, ovr}, 16'h0);
    chk("R9 sticky holds", {15'b0, ovr_s}, 16'h1);
    reg_write(4'h2, 16'h0, 1'b1);
    chk("R9 sticky cleared", {15'b0, ovr_s}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_threshold;
    t_ignore;
    t_regs;
    t_saturate;
    t_fast;
    t_sticky;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule